// File: doc/BRIEF.md
# Transmit Data Chunk Header Parser

This block sits on the device side of a full-duplex serial link. It takes the host's transmit chunks one bit at a time, most significant bit first. A chunk-select strobe, active low, frames the traffic. A single select window may hold several chunks back to back. Each chunk is a 32-bit header followed by a 64-byte payload.

The block checks the header's odd parity and decodes its flags. It then forwards only the payload bytes that belong to an Ethernet frame, as a byte stream with start and end markers. A frame may span many chunks. The start of a frame is located by a word offset and the end by a byte offset, and both can occur in the same chunk.

A transmit credit counter limits how many data-carrying chunks the host may send before the downstream buffer releases space. A chunk sent with no credit left raises an overflow pulse and is discarded. The block also reports the sequence bit, the no-receive request and the timestamp request code of every accepted header, so the receive side and the timestamp logic can act on them.

Top module: `txc_chunk_parser`

## Requirements
- R1: Bits are taken MSB first, one per cycle with `bit_vld_i` high and `cs_ni` low. The first 32 bits form the header and the next 512 bits form the payload, after which a new header starts. A high `cs_ni` returns the block to the header phase. A header whose bit 31 is 0 produces no `hdr_vld_o` pulse, no bytes and no credit change.
- R2: A header with even parity over all 32 bits sets `hdr_bad_o`, and its payload is discarded with no credit taken. A header with odd parity clears `hdr_bad_o`. Both take effect one cycle after the header's last bit.
- R3: A header with odd parity, bit 31 = 1 and bit 21 = 1, arriving when `credits_o` is 0, produces a one-cycle `overflow_o` pulse. Its payload is discarded and the credit count is unchanged.
- R4: `credits_o` resets to CREDITS. It drops by one a cycle after the last bit of an accepted header (odd parity, bit 31 = 1, bit 21 = 1, credit available). It rises by one a cycle after a `credit_rel_i` pulse, saturating at CREDITS. A take and a release in the same cycle leave it unchanged.
- R5: A header with bit 21 = 0 emits no payload bytes and takes no credit, but still pulses `hdr_vld_o`.
- R6: With bit 20 = 1, the byte at payload index 4 × bits 19:16 is emitted with `byte_sof_o` high, and the bytes after it continue the frame.
- R7: With bit 14 = 1, an open frame is emitted up to and including payload index bits 13:8, and that last byte carries `byte_eof_o`. A frame left open at the end of a chunk resumes at index 0 of the next accepted chunk.
- R8: When a chunk with bits 20 and 14 set arrives while a frame is open, the open frame ends at the end offset and the new frame starts at the later start offset, within the same chunk.
- R9: Payload bytes outside any frame are never emitted.
- R10: `hdr_vld_o` pulses for one cycle, one cycle after the last bit of every header with odd parity and bit 31 = 1. During the pulse, `hdr_seq_o` = bit 30, `hdr_norx_o` = bit 29 and `ts_code_o` = bits 7:6.
- R11: Each emitted byte appears on `byte_data_o` with `byte_vld_o` high, one cycle after the clock edge that takes its eighth bit.
- R12: After reset, every output is 0 except `credits_o`, which equals CREDITS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chunk select, active low |
| bit_vld_i | input | 1 | Serial bit strobe |
| bit_i | input | 1 | Serial data bit |
| credit_rel_i | input | 1 | Downstream returns one credit |
| byte_vld_o | output | 1 | Frame byte valid |
| byte_data_o | output | 8 | Frame byte |
| byte_sof_o | output | 1 | First byte of a frame |
| byte_eof_o | output | 1 | Last byte of a frame |
| hdr_vld_o | output | 1 | Data header accepted pulse |
| hdr_seq_o | output | 1 | Sequence bit of that header |
| hdr_norx_o | output | 1 | No-receive request of that header |
| ts_code_o | output | 2 | Timestamp request code of that header |
| hdr_bad_o | output | 1 | Last header failed parity |
| overflow_o | output | 1 | Chunk sent without credit |
| credits_o | output | $clog2(CREDITS+1) | Available transmit credits |

## Verification
The hardest situation to reach is a chunk that closes one frame and opens another. It needs a frame already open from an earlier chunk, so the stimulus first opens a frame near the very end of a payload. The next chunk then carries an end offset below its start offset. Overflow needs every credit spent, including one taken by a chunk abandoned halfway by a rising select. That aborted chunk also leaves a frame open, and a later chunk must still close it after the credits are restored by a burst of releases.

// File: rtl/txc_pkg.sv
package txc_pkg;
    localparam int HDR_BITS  = 32;
    localparam int PAY_BYTES = 64;
    localparam int SWO_W     = 4;
    localparam int EBO_W     = 6;

    typedef struct packed {
        logic             is_data;
        logic             par_ok;
        logic             seq;
        logic             norx;
        logic             dv;
        logic             sv;
        logic [SWO_W-1:0] swo;
        logic             ev;
        logic [EBO_W-1:0] ebo;
        logic [1:0]       ts;
    } hdr_t;
endpackage

// File: rtl/txc_hdr_decode.sv
module txc_hdr_decode
    import txc_pkg::*;
(
    input  logic [HDR_BITS-1:0] word_i,
    output hdr_t                hdr_o
);
    always_comb begin
        hdr_o.is_data = word_i[31];
        hdr_o.par_ok  = ^word_i;
        hdr_o.seq     = word_i[30];
        hdr_o.norx    = word_i[29];
        hdr_o.dv      = word_i[21];
        hdr_o.sv      = word_i[20];
        hdr_o.swo     = word_i[19:16];
        hdr_o.ev      = word_i[14];
        hdr_o.ebo     = word_i[13:8];
        hdr_o.ts      = word_i[7:6];
    end
endmodule

// File: rtl/txc_bit_shifter.sv
module txc_bit_shifter #(
    parameter  int HDR_BITS  = 32,
    parameter  int PAY_BYTES = 64,
    localparam int TOTAL     = HDR_BITS + 8 * PAY_BYTES,
    localparam int CW        = $clog2(TOTAL),
    localparam int IW        = $clog2(PAY_BYTES)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                cs_ni,
    input  logic                bit_vld_i,
    input  logic                bit_i,
    output logic                hdr_done_o,
    output logic [HDR_BITS-1:0] hdr_word_o,
    output logic                byte_done_o,
    output logic [7:0]          byte_o,
    output logic [IW-1:0]       byte_idx_o
);
    typedef struct packed {
        logic [CW-1:0]       cnt;
        logic [HDR_BITS-1:0] sr;
    } st_t;

    st_t           st_d, st_q;
    logic [CW-1:0] pay_bit;

    always_comb begin
        st_d        = st_q;
        pay_bit     = st_q.cnt - CW'(HDR_BITS);
        hdr_done_o  = 1'b0;
        byte_done_o = 1'b0;
        hdr_word_o  = {st_q.sr[HDR_BITS-2:0], bit_i};
        byte_o      = {st_q.sr[6:0], bit_i};
        byte_idx_o  = IW'(pay_bit >> 3);
        if (cs_ni) begin
            st_d.cnt = '0;
        end else if (bit_vld_i) begin
            st_d.sr = hdr_word_o;
            if (st_q.cnt == CW'(HDR_BITS - 1)) begin
                hdr_done_o = 1'b1;
            end
            if (st_q.cnt >= CW'(HDR_BITS) && pay_bit[2:0] == 3'd7) begin
                byte_done_o = 1'b1;
            end
            st_d.cnt = (st_q.cnt == CW'(TOTAL - 1)) ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/txc_credit_ctr.sv
module txc_credit_ctr #(
    parameter  int CREDITS = 8,
    localparam int CW      = $clog2(CREDITS + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          take_i,
    input  logic          give_i,
    output logic [CW-1:0] count_o,
    output logic          empty_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (take_i && !give_i) begin
            cnt_d = cnt_q - 1'b1;
        end else if (give_i && !take_i && cnt_q != CW'(CREDITS)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= CW'(CREDITS);
        else         cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
    assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/txc_chunk_parser.sv
module txc_chunk_parser
    import txc_pkg::*;
#(
    parameter  int CREDITS = 8,
    localparam int CRED_W  = $clog2(CREDITS + 1),
    localparam int IW      = $clog2(PAY_BYTES)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cs_ni,
    input  logic              bit_vld_i,
    input  logic              bit_i,
    input  logic              credit_rel_i,
    output logic              byte_vld_o,
    output logic [7:0]        byte_data_o,
    output logic              byte_sof_o,
    output logic              byte_eof_o,
    output logic              hdr_vld_o,
    output logic              hdr_seq_o,
    output logic              hdr_norx_o,
    output logic [1:0]        ts_code_o,
    output logic              hdr_bad_o,
    output logic              overflow_o,
    output logic [CRED_W-1:0] credits_o
);
    typedef struct packed {
        logic             chunk_ok;
        logic             in_frame;
        logic             sv_pend;
        logic             ev_pend;
        logic [SWO_W-1:0] swo;
        logic [EBO_W-1:0] ebo;
        logic             byte_vld;
        logic [7:0]       byte_data;
        logic             sof;
        logic             eof;
        logic             hdr_vld;
        logic             seq;
        logic             norx;
        logic [1:0]       ts;
        logic             hdr_bad;
        logic             ovf;
    } st_t;

    st_t                 st_d, st_q;
    logic                hdr_done, byte_done;
    logic [HDR_BITS-1:0] hdr_word;
    logic [7:0]          pay_byte;
    logic [IW-1:0]       byte_idx;
    hdr_t                hdr;
    logic                take, cred_empty;
    logic                start_hit, end_hit;

    txc_bit_shifter #(.HDR_BITS(HDR_BITS), .PAY_BYTES(PAY_BYTES)) shift_i (
        .clk_i, .rst_ni, .cs_ni, .bit_vld_i, .bit_i,
        .hdr_done_o (hdr_done),
        .hdr_word_o (hdr_word),
        .byte_done_o(byte_done),
        .byte_o     (pay_byte),
        .byte_idx_o (byte_idx)
    );

    txc_hdr_decode dec_i (.word_i(hdr_word), .hdr_o(hdr));

    txc_credit_ctr #(.CREDITS(CREDITS)) cred_i (
        .clk_i, .rst_ni,
        .take_i (take),
        .give_i (credit_rel_i),
        .count_o(credits_o),
        .empty_o(cred_empty)
    );

    always_comb begin
        st_d          = st_q;
        st_d.byte_vld = 1'b0;
        st_d.sof      = 1'b0;
        st_d.eof      = 1'b0;
        st_d.hdr_vld  = 1'b0;
        st_d.ovf      = 1'b0;
        take          = 1'b0;
        start_hit     = st_q.sv_pend && (byte_idx == IW'({st_q.swo, 2'b00}));
        end_hit       = st_q.ev_pend && (byte_idx == IW'(st_q.ebo));

        if (hdr_done) begin
            st_d.hdr_bad  = !hdr.par_ok;
            st_d.chunk_ok = 1'b0;
            if (hdr.par_ok && hdr.is_data) begin
                st_d.hdr_vld = 1'b1;
                st_d.seq     = hdr.seq;
                st_d.norx    = hdr.norx;
                st_d.ts      = hdr.ts;
                if (hdr.dv) begin
                    if (cred_empty) begin
                        st_d.ovf = 1'b1;
                    end else begin
                        take          = 1'b1;
                        st_d.chunk_ok = 1'b1;
                        st_d.sv_pend  = hdr.sv;
                        st_d.ev_pend  = hdr.ev;
                        st_d.swo      = hdr.swo;
                        st_d.ebo      = hdr.ebo;
                    end
                end
            end
        end

        if (byte_done && st_q.chunk_ok) begin
            st_d.byte_data = pay_byte;
            if (st_q.in_frame) begin
                st_d.byte_vld = 1'b1;
                if (end_hit) begin
                    st_d.eof      = 1'b1;
                    st_d.in_frame = 1'b0;
                    st_d.ev_pend  = 1'b0;
                end
            end else if (start_hit) begin
                st_d.byte_vld = 1'b1;
                st_d.sof      = 1'b1;
                st_d.in_frame = 1'b1;
                st_d.sv_pend  = 1'b0;
                if (end_hit) begin
                    st_d.eof      = 1'b1;
                    st_d.in_frame = 1'b0;
                    st_d.ev_pend  = 1'b0;
                end
            end else if (end_hit) begin
                st_d.ev_pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign byte_vld_o  = st_q.byte_vld;
    assign byte_data_o = st_q.byte_data;
    assign byte_sof_o  = st_q.sof;
    assign byte_eof_o  = st_q.eof;
    assign hdr_vld_o   = st_q.hdr_vld;
    assign hdr_seq_o   = st_q.seq;
    assign hdr_norx_o  = st_q.norx;
    assign ts_code_o   = st_q.ts;
    assign hdr_bad_o   = st_q.hdr_bad;
    assign overflow_o  = st_q.ovf;
endmodule

// File: rtl/txc_chunk_parser_chk.sv
module txc_chunk_parser_chk #(
    parameter  int CREDITS = 8,
    localparam int CRED_W  = $clog2(CREDITS + 1)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              cs_ni,
    input logic              bit_vld_i,
    input logic              bit_i,
    input logic              credit_rel_i,
    input logic              byte_vld_o,
    input logic [7:0]        byte_data_o,
    input logic              byte_sof_o,
    input logic              byte_eof_o,
    input logic              hdr_vld_o,
    input logic              hdr_seq_o,
    input logic              hdr_norx_o,
    input logic [1:0]        ts_code_o,
    input logic              hdr_bad_o,
    input logic              overflow_o,
    input logic [CRED_W-1:0] credits_o
);
    assert_credit_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        credits_o <= CRED_W'(CREDITS));

    assert_credit_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (credits_o == $past(credits_o)) || (credits_o == $past(credits_o) + 1'b1)
        || (credits_o == $past(credits_o) - 1'b1));

    assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        overflow_o |-> (credits_o == '0) && !byte_vld_o);

    assert_ovf_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        overflow_o |=> !overflow_o);

    assert_hdr_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hdr_vld_o |=> !hdr_vld_o);

    assert_good_hdr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hdr_vld_o |-> !hdr_bad_o);

    assert_marks_need_byte_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (byte_sof_o || byte_eof_o) |-> byte_vld_o);

    assert_idle_select_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(cs_ni) |-> !byte_vld_o && !hdr_vld_o);
endmodule

bind txc_chunk_parser txc_chunk_parser_chk #(.CREDITS(CREDITS)) chk_i (.*);

// File: tb/txc_chunk_parser_tb_top.sv
`timescale 1ns/1ps
module txc_chunk_parser_tb_top;
    localparam int CREDITS = 8;
    localparam int CW      = $clog2(CREDITS + 1);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n = 1'b0, cs_n = 1'b1, bvld = 1'b0, bval = 1'b0, rel = 1'b0;
    logic          byte_vld, sof, eof, hvld, hseq, hnorx, hbad, ovf;
    logic [7:0]    bdata;
    logic [1:0]    ts;
    logic [CW-1:0] cred;

    txc_chunk_parser #(.CREDITS(CREDITS)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .bit_vld_i(bvld), .bit_i(bval),
        .credit_rel_i(rel), .byte_vld_o(byte_vld), .byte_data_o(bdata),
        .byte_sof_o(sof), .byte_eof_o(eof), .hdr_vld_o(hvld), .hdr_seq_o(hseq),
        .hdr_norx_o(hnorx), .ts_code_o(ts), .hdr_bad_o(hbad), .overflow_o(ovf),
        .credits_o(cred)
    );

    int vectors = 0, errors = 0;
    bit run = 0;
    logic [9:0] expq[$];
    int m_cred = CREDITS;
    bit m_bad, m_ovf, m_hv, m_seq, m_norx, m_open;
    bit [1:0] m_ts;

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (run) begin
        logic [9:0] e;
        chk("R4 credits", int'(cred), m_cred);
        chk("R2 hdr_bad", int'(hbad), int'(m_bad));
        chk("R3 overflow", int'(ovf), int'(m_ovf));
        chk("R10 hdr_vld", int'(hvld), int'(m_hv));
        if (m_hv) begin
            chk("R10 seq", int'(hseq), int'(m_seq));
            chk("R10 norx", int'(hnorx), int'(m_norx));
            chk("R10 ts code", int'(ts), int'(m_ts));
        end
        if (byte_vld) begin
            if (expq.size() == 0) chk("R9 unexpected byte", 1, 0);
            else begin
                e = expq.pop_front();
                chk("R11 byte data", int'(bdata), int'(e[9:2]));
                chk("R6 sof", int'(sof), int'(e[1]));
                chk("R7 eof", int'(eof), int'(e[0]));
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
        m_ovf = 0;
        m_hv  = 0;
    endtask

    task automatic send_bit(bit b);
        bvld = 1'b1; bval = b;
        tick();
        bvld = 1'b0;
    endtask

    task automatic release_credit();
        rel = 1'b1;
        tick();
        rel = 1'b0;
        if (m_cred < CREDITS) m_cred++;
    endtask

    task automatic send_chunk(bit dnc, bit good, bit seq, bit norx, bit dv, bit sv,
                              int swo, bit ev, int ebo, int tsc, int nbytes, int seed);
        logic [31:0] w;
        bit acc, svp, evp, st, en;
        w = '0;
        w[31] = dnc; w[30] = seq; w[29] = norx; w[21] = dv; w[20] = sv;
        w[19:16] = 4'(swo); w[14] = ev; w[13:8] = 6'(ebo); w[7:6] = 2'(tsc);
        w[0] = ~^w[31:1];
        if (!good) w[0] = ~w[0];
        cs_n = 1'b0;
        for (int i = 31; i >= 0; i--) send_bit(w[i]);
        acc = 0;
        m_bad = !good;
        if (good && dnc) begin
            m_hv = 1; m_seq = seq; m_norx = norx; m_ts = 2'(tsc);
            if (dv) begin
                if (m_cred == 0) m_ovf = 1;
                else begin m_cred--; acc = 1; end
            end
        end
        svp = sv; evp = ev;
        for (int k = 0; k < nbytes; k++) begin
            logic [7:0] d;
            d = 8'(seed * 7 + k);
            if (acc) begin
                st = svp && (k == swo * 4);
                en = evp && (k == ebo);
                if (m_open) begin
                    expq.push_back({d, 1'b0, en});
                    if (en) begin m_open = 0; evp = 0; end
                end else if (st) begin
                    expq.push_back({d, 1'b1, en});
                    svp = 0; m_open = 1;
                    if (en) begin m_open = 0; evp = 0; end
                end else if (en) evp = 0;
            end
            for (int i = 7; i >= 0; i--) send_bit(d[i]);
        end
        cs_n = 1'b1;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        @(posedge clk); #1;
        run = 1;
        tick(); tick();
        chk("R12 reset credits", int'(cred), CREDITS);
        chk("R12 reset byte_vld", int'(byte_vld), 0);
        rst_n = 1'b1;
        tick();
        // R1: control header (bit 31 = 0) is not a data chunk
        send_chunk(0, 1, 0, 0, 1, 1, 0, 0, 0, 0, 64, 1);
        // R6: frame opens at word 0
        send_chunk(1, 1, 0, 0, 1, 1, 0, 0, 0, 0, 64, 2);
        // R7: frame closes at byte 9
        send_chunk(1, 1, 1, 0, 1, 0, 0, 1, 9, 0, 64, 3);
        // R6 R7: frame wholly inside one chunk
        send_chunk(1, 1, 0, 1, 1, 1, 2, 1, 20, 1, 64, 4);
        // frame opens in the last word
        send_chunk(1, 1, 1, 0, 1, 1, 15, 0, 0, 0, 64, 5);
        // R8: end of old frame and start of new one in the same chunk
        send_chunk(1, 1, 1, 1, 1, 1, 4, 1, 3, 2, 64, 6);
        send_chunk(1, 1, 0, 0, 1, 0, 0, 1, 63, 0, 64, 7);
        // R5: data-valid clear
        send_chunk(1, 1, 0, 0, 0, 1, 0, 0, 0, 1, 64, 8);
        // R2: parity failure, then a good header clears it; R9 no frame open
        send_chunk(1, 0, 0, 0, 1, 1, 0, 0, 0, 0, 64, 9);
        send_chunk(1, 1, 0, 0, 1, 0, 0, 0, 0, 0, 64, 10);
        // R1: chunk cut short by select, leaves frame open, last credit taken
        send_chunk(1, 1, 0, 0, 1, 1, 0, 0, 0, 0, 5, 11);
        // R3: no credit left
        send_chunk(1, 1, 0, 0, 1, 1, 0, 1, 10, 0, 64, 12);
        // R4: releases saturate
        for (int i = 0; i < CREDITS + 2; i++) release_credit();
        // R7: open frame closes in the next accepted chunk
        send_chunk(1, 1, 1, 1, 1, 0, 0, 1, 2, 3, 64, 13);
        tick(); tick();
        chk("R9 leftover expected bytes", expq.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule